// File: doc/BRIEF.md
# Three-Wire Serial Tuning Register

This block is the receiving end of a three-wire host bus (data, clock, enable) that programs a frequency synthesizer. While the enable line is high, each rising edge of the bus clock shifts one data bit into an internal shift register. When enable falls, the assembled word moves into holding registers. These registers drive a divisor value for the synthesizer's programmable divider and four independent port-control outputs.

A static mode pin sets the word length. When the pin is high, the word is 18 bits and carries a 14-bit divisor, and the divisor's top bit is forced to zero. When the pin is low, the word is 19 bits and carries a 15-bit divisor. All three bus lines pass through a two-flop synchronizer into the system clock domain, and edges are detected there. The bus may therefore run much slower than the system clock and with no fixed phase relation to it.

Top module: `tune_serial_loader`

## Requirements
- R1: While rst_ni is low, and after its release, divisor_o reads 0, port_o reads 0 (all ports off) and load_strobe_o reads 0.
- R2: Bus clock edges are ignored while bus_en_i is low. An enable window that contains no clock edges reloads the previous shift contents unchanged.
- R3: divisor_o and port_o keep their values until bus_en_i falls, including while a new word is being shifted in.
- R4: Bits arrive MSB first. The last bit shifted before enable falls becomes word bit 0. The four lowest word bits drive port_o[3:0] bit for bit: the first port bit sent lands on port_o[3] and the last on port_o[0]. The bits above them form the divisor.
- R5: With mode_short_i high, the word is 18 bits. divisor_o[13:0] takes word bits 17..4, and divisor_o[14] is 0.
- R6: With mode_short_i low, the word is 19 bits. divisor_o[14:0] takes word bits 18..4.
- R7: If the number of bits clocked in a window differs from the word length, the most recently shifted bits fill the word.
- R8: load_strobe_o is high for exactly one system clock cycle per enable falling edge. It is asserted in the same cycle that divisor_o and port_o take their new values, on the third rising clk_i edge after bus_en_i goes low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_clk_i | input | 1 | Serial bus clock, asynchronous |
| bus_dat_i | input | 1 | Serial bus data, asynchronous |
| bus_en_i | input | 1 | Serial bus enable, asynchronous |
| mode_short_i | input | 1 | 1: 18-bit word with 14-bit divisor; 0: 19-bit word with 15-bit divisor |
| divisor_o | output | 15 | Held divisor |
| port_o | output | 4 | Held port-control bits |
| load_strobe_o | output | 1 | One-cycle pulse when new values are latched |

## Verification
The main function is exercised with words in both modes. Walking-pattern words separate the divisor field from the port field, and all-ones words show whether the top divisor bit is correctly masked in short mode. Words that are too long in either mode, including a 19-bit word decoded in short mode, show whether the register keeps the most recent bits rather than the first ones. Clock pulses sent while enable is low, followed by an empty enable window, distinguish a design that gates the clock from one that does not. A mode change at reload shows that the mask is applied when the word is latched.

// File: rtl/tune_pkg.sv
package tune_pkg;
  typedef struct packed {
    logic clk;
    logic dat;
    logic en;
  } bus_t;
  localparam int unsigned BUS_W = $bits(bus_t);
endpackage

// File: rtl/tune_sync.sv
module tune_sync #(
  parameter int unsigned WIDTH  = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stg_q[s] <= '0;
        else         stg_q[s] <= d_i;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stg_q[s] <= '0;
        else         stg_q[s] <= stg_q[s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/tune_shift.sv
module tune_shift #(
  parameter int unsigned WORD_W = 19
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bclk_s_i,
  input  logic              bdat_s_i,
  input  logic              ben_s_i,
  output logic [WORD_W-1:0] word_o
);
  logic              bclk_prev_q;
  logic [WORD_W-1:0] sh_q;
  logic              shift_en;

  assign shift_en = ben_s_i & bclk_s_i & ~bclk_prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bclk_prev_q <= 1'b0;
      sh_q        <= '0;
    end else begin
      bclk_prev_q <= bclk_s_i;
      if (shift_en) sh_q <= {sh_q[WORD_W-2:0], bdat_s_i};
    end
  end

  assign word_o = sh_q;

  // R2
  shift_gated_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ben_s_i |=> $stable(sh_q));
endmodule

// File: rtl/tune_hold.sv
module tune_hold #(
  parameter int unsigned DIV_W  = 15,
  parameter int unsigned PORT_W = 4,
  localparam int unsigned WORD_W = DIV_W + PORT_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              mode_short_i,
  input  logic [WORD_W-1:0] word_i,
  output logic [DIV_W-1:0]  divisor_o,
  output logic [PORT_W-1:0] port_o,
  output logic              strobe_o
);
  logic [DIV_W-1:0] div_next;

  always_comb begin
    if (mode_short_i) div_next = {1'b0, word_i[WORD_W-2:PORT_W]};
    else              div_next = word_i[WORD_W-1:PORT_W];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      divisor_o <= '0;
      port_o    <= '0;
      strobe_o  <= 1'b0;
    end else begin
      strobe_o <= load_i;
      if (load_i) begin
        divisor_o <= div_next;
        port_o    <= word_i[PORT_W-1:0];
      end
    end
  end

  // R3
  hold_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !strobe_o |-> ($stable(divisor_o) && $stable(port_o)));
  // R5
  short_msb_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strobe_o && $past(mode_short_i)) |-> !divisor_o[DIV_W-1]);
endmodule

// File: rtl/tune_serial_loader.sv
module tune_serial_loader
  import tune_pkg::*;
#(
  parameter int unsigned DIV_W       = 15,
  parameter int unsigned PORT_W      = 4,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned WORD_W     = DIV_W + PORT_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_clk_i,
  input  logic              bus_dat_i,
  input  logic              bus_en_i,
  input  logic              mode_short_i,
  output logic [DIV_W-1:0]  divisor_o,
  output logic [PORT_W-1:0] port_o,
  output logic              load_strobe_o
);
  bus_t              bus_raw, bus_s;
  logic              en_prev_q;
  logic              en_fall;
  logic [WORD_W-1:0] word;

  assign bus_raw = '{clk: bus_clk_i, dat: bus_dat_i, en: bus_en_i};

  tune_sync #(.WIDTH(BUS_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (bus_raw),
    .q_o    (bus_s)
  );

  tune_shift #(.WORD_W(WORD_W)) u_shift (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .bclk_s_i (bus_s.clk),
    .bdat_s_i (bus_s.dat),
    .ben_s_i  (bus_s.en),
    .word_o   (word)
  );

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) en_prev_q <= 1'b0;
    else         en_prev_q <= bus_s.en;

  assign en_fall = en_prev_q & ~bus_s.en;

  tune_hold #(.DIV_W(DIV_W), .PORT_W(PORT_W)) u_hold (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .load_i       (en_fall),
    .mode_short_i (mode_short_i),
    .word_i       (word),
    .divisor_o    (divisor_o),
    .port_o       (port_o),
    .strobe_o     (load_strobe_o)
  );

  // R8
  strobe_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_strobe_o |=> !load_strobe_o);
  // R8
  strobe_after_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_strobe_o |-> $past(en_prev_q));
endmodule

// File: tb/tune_serial_loader_test.sv
module tune_serial_loader_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bclk = 1'b0, bdat = 1'b0, ben = 1'b0, mode = 1'b0;
  logic [14:0] div;
  logic [3:0]  prt;
  logic        stb;
  int          n_run = 0, n_fail = 0, cyc = 0, n_stb = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (stb) n_stb <= n_stb + 1;
  end

  tune_serial_loader uut (
    .clk_i(clk), .rst_ni(rst_n), .bus_clk_i(bclk), .bus_dat_i(bdat),
    .bus_en_i(ben), .mode_short_i(mode), .divisor_o(div), .port_o(prt),
    .load_strobe_o(stb)
  );

  typedef struct packed {
    logic        m;
    logic [7:0]  nb;
    logic [31:0] w;
    logic [14:0] ed;
    logic [3:0]  ep;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{1'b1, 8'd18, 32'h0001234A, 15'h1234, 4'hA},  // R4 R5
    '{1'b0, 8'd19, 32'h0007ABC5, 15'h7ABC, 4'h5},  // R4 R6
    '{1'b1, 8'd19, 32'h0004F0F3, 15'h0F0F, 4'h3},  // R5 R7
    '{1'b0, 8'd22, 32'h00380018, 15'h0001, 4'h8},  // R7
    '{1'b0, 8'd19, 32'h0007FFFF, 15'h7FFF, 4'hF},  // R6
    '{1'b1, 8'd18, 32'h0003FFFF, 15'h3FFF, 4'hF}   // R5
  };

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic send_bit(input logic b);
    bdat = b;
    wait_cyc(4);
    bclk = 1'b1;
    wait_cyc(4);
    bclk = 1'b0;
    wait_cyc(4);
  endtask

  task automatic send_word(input logic [31:0] w, input int nb, input bit drop);
    ben = 1'b1;
    wait_cyc(4);
    for (int i = nb - 1; i >= 0; i--) send_bit(w[i]);
    if (drop) begin
      ben = 1'b0;
      wait_cyc(6);
    end
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    wait (cyc >= 150000);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: actual %0d expected <150000 cycles", cyc);
    finish_run();
  end

  initial begin
    int s0;
    wait_cyc(3);
    // R1
    check("R1 div in reset", 32'(div), 0);
    check("R1 port in reset", 32'(prt), 0);
    rst_n = 1'b1;
    wait_cyc(3);
    check("R1 div after reset", 32'(div), 0);
    check("R1 port after reset", 32'(prt), 0);
    check("R1 strobe after reset", 32'(stb), 0);

    foreach (VECS[k]) begin
      mode = VECS[k].m;
      send_word(VECS[k].w, int'(VECS[k].nb), 1'b1);
      check($sformatf("R4 divisor vec %0d", k), 32'(div), 32'(VECS[k].ed));
      check($sformatf("R4 port vec %0d", k), 32'(prt), 32'(VECS[k].ep));
    end

    // R3: shift a whole new word, hold enable high, outputs unchanged
    mode = 1'b0;
    send_word(32'h00012345, 19, 1'b0);
    check("R3 divisor held", 32'(div), 32'h3FFF);
    check("R3 port held", 32'(prt), 32'hF);
    // R8: strobe on exactly the third edge after enable falls
    s0 = n_stb;
    ben = 1'b0;
    @(posedge clk); @(posedge clk);
    #1 check("R8 no strobe before third edge", 32'(stb), 0);
    @(posedge clk);
    #1 check("R8 strobe on third edge", 32'(stb), 1);
    check("R8 outputs with strobe", 32'(div), 32'h1234);
    @(posedge clk);
    #1 check("R8 strobe one cycle", 32'(stb), 0);
    wait_cyc(4);
    check("R8 one strobe per fall", 32'(n_stb - s0), 1);
    check("R6 divisor 12345", 32'(div), 32'h1234);
    check("R4 port 12345", 32'(prt), 32'h5);

    // R2: clock pulses with enable low are ignored
    for (int i = 0; i < 8; i++) send_bit(1'b1);
    check("R2 divisor untouched", 32'(div), 32'h1234);
    send_word(32'h0, 0, 1'b1);
    check("R2 empty window divisor", 32'(div), 32'h1234);
    check("R2 empty window port", 32'(prt), 32'h5);

    // R5: reload in short mode after a word with the top bit set
    send_word(32'h0007FFF0, 19, 1'b1);
    check("R6 top bit kept", 32'(div), 32'h7FFF);
    mode = 1'b1;
    send_word(32'h0, 0, 1'b1);
    check("R5 top bit masked on reload", 32'(div), 32'h3FFF);
    check("R5 port on reload", 32'(prt), 32'h0);

    // R1: asynchronous reset clears held values
    rst_n = 1'b0;
    wait_cyc(2);
    check("R1 div cleared", 32'(div), 0);
    rst_n = 1'b1;
    wait_cyc(2);
    finish_run();
  end
endmodule